// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Refresh Arbitration

This block connects a simple processor-side bus to an array of asynchronous DRAM devices whose row and column addresses share one set of pins. A bus master raises a read or write together with the module select and holds it until the controller answers with a one-cycle ready pulse. The controller latches the address and write data, strobes the row half of the address with RAS, then the column half with CAS, and closes every RAS cycle with a precharge gap before another may begin.

A refresh timer raises a refresh request at a fixed interval. The default interval covers all 1024 rows within 8 ms at the default clock rate. An arbiter grants that request whenever the controller is idle. A processor access already under way is never cut short, so a refresh that arrives during it waits and runs straight after it. Refresh runs either as a RAS-only cycle that drives the controller's own row counter, or, when the mode input selects it, as a cycle in which CAS falls before RAS so that the device's internal counter picks the row. All strobe widths are whole clock cycles set by parameters.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While reset is applied, RAS, CAS and write-enable are high (inactive), the data-drive enable is low and ready is low.
- R2: An accepted access drives the row half (address bits [19:10]) on the DRAM address pins with RAS low and CAS high for T_RCD cycles. It then drives the column half (bits [9:0]) with RAS and CAS both low for T_CAS cycles.
- R3: During the column phase of a write, write-enable is low, the data-drive enable is high and the latched write data is on the data output. During a read, write-enable stays high and the drive enable stays low for the whole access.
- R4: Ready is high for exactly one cycle: the first precharge cycle after the column phase. For a read, the read data output then holds the DRAM data input as sampled in the last column cycle.
- R5: After every RAS cycle, RAS and CAS stay high for at least T_PRE cycles, and then for one idle cycle, before any strobe falls again. While idle the DRAM address pins read zero.
- R6: The refresh timer raises a request on every REF_PERIOD_CYC-th clock after reset. A request stays pending until it is granted, and a refresh cycle starts in the cycle after the idle cycle in which it is granted.
- R7: A RAS-only refresh drives the refresh row counter on the address pins with RAS low for T_REF_RAS cycles. During it CAS stays high, the drive enable stays low and no ready is produced.
- R8: The refresh row counter starts at 0, advances by one after each RAS-only refresh and wraps from 1023 to 0.
- R9: If the mode input is high at grant time, the refresh holds CAS low with RAS high for one cycle. It then holds both low for T_REF_RAS cycles, drives zero on the address pins and leaves the row counter unchanged.
- R10: If a refresh request and a latched processor request are both pending in an idle cycle, the refresh is granted first. The processor request keeps the address, direction and data captured when it was accepted until it is served.
- R11: Read or write strobes with the module select low are ignored, and no DRAM cycle results from them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mod_sel | input | 1 | Module select from the bus |
| bus_rd | input | 1 | Read strobe, held until ready |
| bus_wr | input | 1 | Write strobe, held until ready; wins over bus_rd |
| bus_addr | input | 20 | Word address: row in [19:10], column in [9:0] |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with ready |
| bus_ready | output | 1 | One-cycle completion pulse |
| refresh_cbr | input | 1 | Selects CAS-before-RAS refresh when high |
| mem_addr | output | 10 | Multiplexed row/column address pins |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_oe | output | 1 | Enables the external data drivers |
| mem_dq_out | output | 16 | Write data towards the devices |
| mem_dq_in | input | 16 | Read data from the devices |

## Verification
The bench builds the block with a refresh period of 60 cycles instead of the roughly thousand-cycle default. At that period every row refresh, the counter's wrap from 1023 back to 0, and many collisions between refresh and back-to-back bus traffic all fall inside a short run. The strobe widths are T_RCD=2, T_CAS=2, T_PRE=2 and T_REF_RAS=3, so every phase lasts more than one cycle and a mistake in a down-counter shows up on the pins. A window with the CAS-before-RAS mode input held high mixes both refresh styles into the same traffic.

// File: rtl/dramc_pkg.sv
package dramc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_PRE,
    ST_REF,
    ST_CBR_CAS,
    ST_CBR_RAS
  } dram_st_e;

  typedef enum logic [1:0] {
    AM_NONE,
    AM_ROW,
    AM_COL,
    AM_REF
  } amux_e;

endpackage

// File: rtl/dramc_refresh.sv
module dramc_refresh #(
  parameter int ROW_BITS = 10,
  parameter int PERIOD   = 976
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                grant,
  input  logic                advance,
  output logic                req,
  output logic [ROW_BITS-1:0] row
);
  localparam int TW   = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam int ROWS = 1 << ROW_BITS;

  logic [TW-1:0]       tmr_q, tmr_d;
  logic                tick;
  logic                req_d;
  logic [ROW_BITS-1:0] row_d;

  always_comb begin
    tick  = (tmr_q == TW'(PERIOD - 1));
    tmr_d = tick ? '0 : tmr_q + TW'(1);
    req_d = req;
    if (tick)       req_d = 1'b1;
    else if (grant) req_d = 1'b0;
    row_d = row;
    if (advance) row_d = (row == ROW_BITS'(ROWS - 1)) ? '0 : row + ROW_BITS'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
      req   <= 1'b0;
      row   <= '0;
    end else begin
      tmr_q <= tmr_d;
      req   <= req_d;
      row   <= row_d;
    end
  end

  // R6: a pending request is not dropped before it is granted
  p_req_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !grant) |=> req);

  // R8: the row counter wraps to zero after the last row
  p_row_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && row == ROW_BITS'(ROWS - 1)) |=> (row == '0));

endmodule

// File: rtl/dramc_addr_mux.sv
module dramc_addr_mux
  import dramc_pkg::*;
#(
  parameter int ROW_BITS = 10,
  parameter int COL_BITS = 10,
  parameter int PIN_W    = 10
) (
  input  amux_e                        pick,
  input  logic [ROW_BITS+COL_BITS-1:0] acc_addr,
  input  logic [ROW_BITS-1:0]          ref_row,
  output logic [PIN_W-1:0]             pins
);
  localparam int AW = ROW_BITS + COL_BITS;

  logic [ROW_BITS-1:0] row_half;
  logic [COL_BITS-1:0] col_half;

  assign row_half = acc_addr[AW-1:COL_BITS];
  assign col_half = acc_addr[COL_BITS-1:0];

  always_comb begin
    case (pick)
      AM_ROW:  pins = PIN_W'(row_half);
      AM_COL:  pins = PIN_W'(col_half);
      AM_REF:  pins = PIN_W'(ref_row);
      default: pins = '0;
    endcase
  end

endmodule

// File: rtl/dramc_timing.sv
module dramc_timing
  import dramc_pkg::*;
#(
  parameter int T_RCD     = 2,
  parameter int T_CAS     = 2,
  parameter int T_PRE     = 2,
  parameter int T_REF_RAS = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ref_req,
  input  logic  cbr_mode,
  input  logic  acc_pend,
  input  logic  acc_wr,
  output logic  ref_grant,
  output logic  ref_adv,
  output logic  cap_rd,
  output logic  ready,
  output logic  ras_n,
  output logic  cas_n,
  output logic  we_n,
  output logic  dq_oe,
  output amux_e pick
);
  localparam int M1   = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int M2   = (T_PRE > T_REF_RAS) ? T_PRE : T_REF_RAS;
  localparam int MAXT = (M1 > M2) ? M1 : M2;
  localparam int CW   = (MAXT > 1) ? $clog2(MAXT + 1) : 1;

  dram_st_e      st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rdy_d;
  logic          last;

  assign last = (cnt_q == '0);

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    rdy_d     = 1'b0;
    ref_grant = 1'b0;
    ref_adv   = 1'b0;
    cap_rd    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (ref_req) begin
          ref_grant = 1'b1;
          if (cbr_mode) begin
            st_d = ST_CBR_CAS;
          end else begin
            st_d  = ST_REF;
            cnt_d = CW'(T_REF_RAS - 1);
          end
        end else if (acc_pend) begin
          st_d  = ST_ROW;
          cnt_d = CW'(T_RCD - 1);
        end
      end
      ST_ROW: begin
        if (last) begin
          st_d  = ST_COL;
          cnt_d = CW'(T_CAS - 1);
        end else cnt_d = cnt_q - CW'(1);
      end
      ST_COL: begin
        if (last) begin
          st_d   = ST_PRE;
          cnt_d  = CW'(T_PRE - 1);
          rdy_d  = 1'b1;
          cap_rd = !acc_wr;
        end else cnt_d = cnt_q - CW'(1);
      end
      ST_REF: begin
        if (last) begin
          st_d    = ST_PRE;
          cnt_d   = CW'(T_PRE - 1);
          ref_adv = 1'b1;
        end else cnt_d = cnt_q - CW'(1);
      end
      ST_CBR_CAS: begin
        st_d  = ST_CBR_RAS;
        cnt_d = CW'(T_REF_RAS - 1);
      end
      ST_CBR_RAS: begin
        if (last) begin
          st_d  = ST_PRE;
          cnt_d = CW'(T_PRE - 1);
        end else cnt_d = cnt_q - CW'(1);
      end
      ST_PRE: begin
        if (last) st_d = ST_IDLE;
        else      cnt_d = cnt_q - CW'(1);
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      ready <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      ready <= rdy_d;
    end
  end

  always_comb begin
    ras_n = 1'b1;
    cas_n = 1'b1;
    we_n  = 1'b1;
    dq_oe = 1'b0;
    pick  = AM_NONE;
    case (st_q)
      ST_ROW: begin
        ras_n = 1'b0;
        pick  = AM_ROW;
      end
      ST_COL: begin
        ras_n = 1'b0;
        cas_n = 1'b0;
        we_n  = !acc_wr;
        dq_oe = acc_wr;
        pick  = AM_COL;
      end
      ST_REF: begin
        ras_n = 1'b0;
        pick  = AM_REF;
      end
      ST_CBR_CAS: cas_n = 1'b0;
      ST_CBR_RAS: begin
        ras_n = 1'b0;
        cas_n = 1'b0;
      end
      default: ;
    endcase
  end

  // R4: ready is a single-cycle pulse
  p_ready_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  // R3: data is driven only while a write strobes CAS
  p_oe_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!cas_n && !we_n && !ras_n));

  // R5: a rising RAS is followed by at least one more high cycle
  p_pre_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> ras_n);

  // R9: when RAS falls with CAS low, CAS was already low
  p_cbr_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

  // R7: ready never accompanies a refresh grant
  p_ref_no_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_grant |=> !ready);

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
  import dramc_pkg::*;
#(
  parameter int ROW_BITS       = 10,
  parameter int COL_BITS       = 10,
  parameter int DATA_W         = 16,
  parameter int T_RCD          = 2,
  parameter int T_CAS          = 2,
  parameter int T_PRE          = 2,
  parameter int T_REF_RAS      = 3,
  parameter int CLK_KHZ        = 125000,
  parameter int RETAIN_US      = 8000,
  parameter int REF_PERIOD_CYC = (CLK_KHZ / 1000) * RETAIN_US / (1 << ROW_BITS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         mod_sel,
  input  logic                         bus_rd,
  input  logic                         bus_wr,
  input  logic [ROW_BITS+COL_BITS-1:0] bus_addr,
  input  logic [DATA_W-1:0]            bus_wdata,
  output logic [DATA_W-1:0]            bus_rdata,
  output logic                         bus_ready,
  input  logic                         refresh_cbr,
  output logic [((ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS)-1:0] mem_addr,
  output logic                         mem_ras_n,
  output logic                         mem_cas_n,
  output logic                         mem_we_n,
  output logic                         mem_dq_oe,
  output logic [DATA_W-1:0]            mem_dq_out,
  input  logic [DATA_W-1:0]            mem_dq_in
);
  localparam int AW    = ROW_BITS + COL_BITS;
  localparam int PIN_W = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS;

  logic sync1_q, sync2_q, rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= 1'b1;
      sync2_q <= sync1_q;
    end
  end
  assign rst_core_n = sync2_q;

  logic              pend_q, wr_q;
  logic [AW-1:0]     addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              bus_req, take;
  logic              ref_req, ref_grant, ref_adv, cap_rd;
  logic [ROW_BITS-1:0] ref_row;
  amux_e             pick;

  assign bus_req = mod_sel && (bus_rd || bus_wr);
  assign take    = !bus_ready && !pend_q && bus_req;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      pend_q <= 1'b0;
    end else if (bus_ready) begin
      pend_q <= 1'b0;
    end else if (take) begin
      pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (take) begin
      wr_q    <= bus_wr;
      addr_q  <= bus_addr;
      wdata_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rdata_q <= '0;
    end else if (cap_rd) begin
      rdata_q <= mem_dq_in;
    end
  end

  assign bus_rdata  = rdata_q;
  assign mem_dq_out = wdata_q;

  dramc_refresh #(
    .ROW_BITS (ROW_BITS),
    .PERIOD   (REF_PERIOD_CYC)
  ) u_refresh (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .grant   (ref_grant),
    .advance (ref_adv),
    .req     (ref_req),
    .row     (ref_row)
  );

  dramc_timing #(
    .T_RCD     (T_RCD),
    .T_CAS     (T_CAS),
    .T_PRE     (T_PRE),
    .T_REF_RAS (T_REF_RAS)
  ) u_timing (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .ref_req   (ref_req),
    .cbr_mode  (refresh_cbr),
    .acc_pend  (pend_q),
    .acc_wr    (wr_q),
    .ref_grant (ref_grant),
    .ref_adv   (ref_adv),
    .cap_rd    (cap_rd),
    .ready     (bus_ready),
    .ras_n     (mem_ras_n),
    .cas_n     (mem_cas_n),
    .we_n      (mem_we_n),
    .dq_oe     (mem_dq_oe),
    .pick      (pick)
  );

  dramc_addr_mux #(
    .ROW_BITS (ROW_BITS),
    .COL_BITS (COL_BITS),
    .PIN_W    (PIN_W)
  ) u_mux (
    .pick     (pick),
    .acc_addr (addr_q),
    .ref_row  (ref_row),
    .pins     (mem_addr)
  );

  // R10: a latched request keeps its address until it is served
  p_req_held_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (pend_q && !bus_ready) |=> ($stable(addr_q) && pend_q));

  // R11: strobes without module select never latch a request
  p_unselected_ignored_r11: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!pend_q && !mod_sel) |=> !pend_q);

  // R10: refresh wins over a pending processor request in an idle cycle
  p_refresh_first_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ref_req && pend_q && mem_ras_n && mem_cas_n && ref_grant) |=> !bus_ready);

endmodule

// File: tb/dram_refresh_ctrl_test.sv
`timescale 1ns/1ps
module dram_refresh_ctrl_test;
  localparam int RB = 10, CB = 10, DW = 16;
  localparam int TRCD = 2, TCAS = 2, TPRE = 2, TREF = 3, PER = 60;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, mod_sel, bus_rd, bus_wr, refresh_cbr;
  logic [19:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata, mem_dq_out, mem_dq_in;
  logic bus_ready, mem_ras_n, mem_cas_n, mem_we_n, mem_dq_oe;
  logic [9:0] mem_addr;

  dram_refresh_ctrl #(
    .ROW_BITS(RB), .COL_BITS(CB), .DATA_W(DW), .T_RCD(TRCD), .T_CAS(TCAS),
    .T_PRE(TPRE), .T_REF_RAS(TREF), .REF_PERIOD_CYC(PER)
  ) uut (
    .clk(clk), .rst_n(rst_n), .mod_sel(mod_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .refresh_cbr(refresh_cbr), .mem_addr(mem_addr),
    .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
    .mem_dq_oe(mem_dq_oe), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in)
  );

  typedef struct packed {
    logic       ras_n;
    logic       cas_n;
    logic       we_n;
    logic       oe;
    logic       rdy;
    logic [9:0] a;
    logic [15:0] d;
    logic [7:0] tag;
  } exp_t;

  exp_t q[$];
  int vectors = 0, fails = 0;
  bit started = 0, done = 0;
  int unsigned n_edges = 0;
  bit m_ref = 0, m_pend = 0, m_wr = 0, m_chk_rd = 0;
  logic [19:0] m_addr = '0;
  logic [15:0] m_wd = '0, m_rexp = '0;
  int m_row = 0;
  int idle_tag = 5;
  int collide = 0;
  bit wrapped = 0, wrap_done = 0;

  function automatic string tname(input int t);
    case (t)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  10: return "R10"; default: return "R11";
    endcase
  endfunction

  function automatic exp_t mk(input logic r, input logic c, input logic w, input logic o,
                              input logic y, input logic [9:0] a, input logic [15:0] d,
                              input int t);
    exp_t e;
    e.ras_n = r; e.cas_n = c; e.we_n = w; e.oe = o; e.rdy = y;
    e.a = a; e.d = d; e.tag = 8'(t);
    return e;
  endfunction

  task automatic fail_line(input int t, input string what, input logic [63:0] act,
                           input logic [63:0] ex);
    fails++;
    $display("FAIL %s %s at %0t: actual %h expected %h", tname(t), what, $time, act, ex);
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      exp_t e;
      logic [14:0] act, exv;
      bit idle;
      bit grant;
      bit req;
      idle = (q.size() == 0);
      e = idle ? mk(1, 1, 1, 0, 0, '0, '0, idle_tag) : q[0];
      act = {mem_ras_n, mem_cas_n, mem_we_n, mem_dq_oe, bus_ready, mem_addr};
      exv = {e.ras_n, e.cas_n, e.we_n, e.oe, e.rdy, e.a};
      vectors++;
      if (act !== exv || (e.oe && mem_dq_out !== e.d))
        fail_line(int'(e.tag), "pins", {33'd0, act, mem_dq_out}, {33'd0, exv, e.d});
      if (e.rdy && m_chk_rd) begin
        vectors++;
        if (bus_rdata !== m_rexp) fail_line(4, "rdata", 64'(bus_rdata), 64'(m_rexp));
      end
      grant = 0;
      if (idle) begin
        if (m_ref) begin
          grant = 1;
          if (m_pend) collide++;
          if (refresh_cbr) begin
            q.push_back(mk(1, 0, 1, 0, 0, '0, '0, 9));
            for (int i = 0; i < TREF; i++) q.push_back(mk(0, 0, 1, 0, 0, '0, '0, 9));
          end else begin
            for (int i = 0; i < TREF; i++)
              q.push_back(mk(0, 1, 1, 0, 0, 10'(m_row), '0,
                             (wrapped && m_row == 0) ? 8 : ((i == 0) ? 6 : 7)));
            if (wrapped && m_row == 0) wrap_done = 1;
            if (m_row == 1023) wrapped = 1;
            m_row = (m_row + 1) % 1024;
          end
          for (int i = 0; i < TPRE; i++) q.push_back(mk(1, 1, 1, 0, 0, '0, '0, 5));
        end else if (m_pend) begin
          m_chk_rd = !m_wr;
          m_rexp = mem_dq_in;
          for (int i = 0; i < TRCD; i++)
            q.push_back(mk(0, 1, 1, 0, 0, m_addr[19:10], '0, 2));
          for (int i = 0; i < TCAS; i++)
            q.push_back(mk(0, 0, !m_wr, m_wr, 0, m_addr[9:0], m_wr ? m_wd : 16'h0,
                           m_wr ? 3 : 2));
          for (int i = 0; i < TPRE; i++)
            q.push_back(mk(1, 1, 1, 0, (i == 0), '0, '0, (i == 0) ? 4 : 5));
        end
      end else begin
        void'(q.pop_front());
      end
      n_edges++;
      if (n_edges % PER == 0) m_ref = 1;
      else if (grant) m_ref = 0;
      req = mod_sel && (bus_rd || bus_wr);
      if (e.rdy) m_pend = 0;
      else if (!m_pend && req) begin
        m_pend = 1; m_wr = bus_wr; m_addr = bus_addr; m_wd = bus_wdata;
      end
    end
  end

  task automatic do_access(input bit wr, input logic [19:0] a, input logic [15:0] d,
                           input logic [15:0] din);
    int k;
    @(posedge clk); #1;
    mem_dq_in = din; mod_sel = 1; bus_wr = wr; bus_rd = !wr; bus_addr = a; bus_wdata = d;
    k = 0;
    do begin
      @(negedge clk); k++;
    end while (!bus_ready && k < 200);
    @(posedge clk); #1;
    mod_sel = 0; bus_rd = 0; bus_wr = 0;
  endtask

  task automatic finish_run();
    vectors++;
    if (collide == 0) fail_line(10, "no refresh/access collision seen", 0, 1);
    vectors++;
    if (!wrap_done) fail_line(8, "row counter wrap not reached", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    rst_n = 0; mod_sel = 0; bus_rd = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    refresh_cbr = 0; mem_dq_in = '0;
    repeat (3) begin
      @(negedge clk);
      vectors++;
      if ({mem_ras_n, mem_cas_n, mem_we_n, mem_dq_oe, bus_ready} !== 5'b11100)
        fail_line(1, "reset pins",
                  64'({mem_ras_n, mem_cas_n, mem_we_n, mem_dq_oe, bus_ready}), 64'(5'b11100));
    end
    rst_n = 1;
    @(posedge clk); @(posedge clk);
    started = 1;
    // R2 R3 R4: directed write then reads
    do_access(1, 20'hABCDE, 16'h1234, 16'h0000);
    do_access(0, 20'hABCDE, 16'h0000, 16'h5A5A);
    do_access(0, 20'h00000, 16'hFFFF, 16'hA5A5);
    do_access(1, 20'hFFFFF, 16'h8001, 16'h0000);
    // R11: strobes without module select
    idle_tag = 11;
    @(posedge clk); #1; bus_rd = 1; bus_addr = 20'h12345;
    repeat (12) @(posedge clk);
    #1; bus_rd = 0; bus_wr = 1;
    repeat (12) @(posedge clk);
    #1; bus_wr = 0;
    repeat (4) @(posedge clk);
    idle_tag = 5;
    // R9: CAS-before-RAS window, then R6 R7 R8 R10 with dense traffic
    seed = 32'h1F2E3D4C;
    for (int i = 0; i < 6500; i++) begin
      refresh_cbr = (i >= 100 && i < 400);
      seed = seed * 1103515245 + 12345;
      do_access(seed[16], seed[31:12], seed[15:0], seed[27:12]);
    end
    refresh_cbr = 0;
    for (int i = 0; i < 30000 && !wrap_done; i++) @(posedge clk);
    repeat (20) @(posedge clk);
    @(negedge clk);
    done = 1;
    finish_run();
  end

endmodule